// File: doc/BRIEF.md
# Cascaded 4-to-16 Active-Low Decoder

This block turns a 4-bit binary code into a 1-out-of-16 active-low selection. It is built from two identical 3-to-8 decoder slices. Each slice needs three enable pins to agree before it pulls any output low: one active-high pin and two active-low pins. The low three code bits go to both slices as their address. The top code bit works as a chip select that wakes exactly one slice. Codes 0 to 7 are decoded by the lower slice, and codes 8 to 15 by the upper slice.

A global active-low enable gates both slices. While it is high, every output stays high, whatever the code. The block is purely combinational. An output follows its inputs within the same cycle, with no register in the path.

Top module: `casc_dec16`

## Requirements
- R1: When `en_n` is 1, all sixteen bits of `dec_n` are 1 for every value of `code`.
- R2: When `en_n` is 0, `dec_n[code]` is 0 and every other bit of `dec_n` is 1.
- R3: When `code[3]` is 0, the upper slice is idle, so `dec_n[15:8]` are all 1.
- R4: When `code[3]` is 1, the lower slice is idle, so `dec_n[7:0]` are all 1.
- R5: For every input combination, at most one bit of `dec_n` is 0.
- R6: The code is read as an unsigned binary number with `code[0]` as the LSB. The address within a slice is ordered `code[2]` (MSB), `code[1]`, `code[0]` (LSB). For example, code 1 lowers `dec_n[1]`, code 4 lowers `dec_n[4]`, and code 6 lowers `dec_n[6]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_n | input | 1 | Global enable, active low |
| code | input | 4 | Binary code to decode |
| dec_n | output | 16 | One-cold decoded lines, active low |

## Verification
Each of the sixteen codes is applied with the enable asserted and again with it negated.
- The enabled pass tells a correct one-cold result apart from a wrong line, a missing line or an extra line.
- The disabled pass catches any leak past the global enable.
- Codes that differ only in `code[3]` show whether the chip select steers the decode to the right slice.
- Codes with a single address bit set (1, 2, 4) show whether the slice address bits are in the right order.

// File: rtl/casc_dec_pkg.sv
package casc_dec_pkg;
  localparam int unsigned SEL_W_DEF  = 1;
  localparam int unsigned SLICE_AW_DEF = 3;

  function automatic int unsigned slice_lines(input int unsigned aw);
    return 1 << aw;
  endfunction
endpackage

// File: rtl/slice_dec.sv
module slice_dec #(
  parameter int unsigned AW = casc_dec_pkg::SLICE_AW_DEF,
  localparam int unsigned NOUT = 1 << AW
) (
  input  logic          g1,
  input  logic          g2a_n,
  input  logic          g2b_n,
  input  logic [AW-1:0] addr,
  output logic [NOUT-1:0] y_n
);
  logic live;
  assign live = g1 & ~g2a_n & ~g2b_n;

  always_comb begin
    y_n = '1;
    if (live) y_n[addr] = 1'b0;
  end
endmodule

// File: rtl/cs_steer.sv
module cs_steer #(
  parameter int unsigned SEL_W = casc_dec_pkg::SEL_W_DEF,
  localparam int unsigned NUNIT = 1 << SEL_W
) (
  input  logic             en_n,
  input  logic [SEL_W-1:0] sel,
  output logic [NUNIT-1:0] g1,
  output logic [NUNIT-1:0] g2a_n,
  output logic [NUNIT-1:0] g2b_n
);
  generate
    if (SEL_W == 1) begin : g_pair
      // Lower slice: chip select on an active-low pin
      assign g1[0]    = 1'b1;
      assign g2a_n[0] = en_n;
      assign g2b_n[0] = sel[0];
      // Upper slice: chip select on the active-high pin
      assign g1[1]    = sel[0];
      assign g2a_n[1] = en_n;
      assign g2b_n[1] = 1'b0;
    end else begin : g_wide
      for (genvar k = 0; k < NUNIT; k++) begin : g_unit
        assign g1[k]    = (sel == SEL_W'(k));
        assign g2a_n[k] = en_n;
        assign g2b_n[k] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/casc_dec16.sv
module casc_dec16 #(
  parameter int unsigned SEL_W    = casc_dec_pkg::SEL_W_DEF,
  parameter int unsigned SLICE_AW = casc_dec_pkg::SLICE_AW_DEF,
  localparam int unsigned IN_W    = SEL_W + SLICE_AW,
  localparam int unsigned NUNIT   = 1 << SEL_W,
  localparam int unsigned SLICE_N = 1 << SLICE_AW,
  localparam int unsigned OUT_W   = NUNIT * SLICE_N
) (
  input  logic             en_n,
  input  logic [IN_W-1:0]  code,
  output logic [OUT_W-1:0] dec_n
);
  logic [NUNIT-1:0] g1, g2a_n, g2b_n;

  cs_steer #(.SEL_W(SEL_W)) u_steer (
    .en_n  (en_n),
    .sel   (code[IN_W-1 -: SEL_W]),
    .g1    (g1),
    .g2a_n (g2a_n),
    .g2b_n (g2b_n)
  );

  generate
    for (genvar u = 0; u < NUNIT; u++) begin : g_slice
      slice_dec #(.AW(SLICE_AW)) u_slice (
        .g1    (g1[u]),
        .g2a_n (g2a_n[u]),
        .g2b_n (g2b_n[u]),
        .addr  (code[SLICE_AW-1:0]),
        .y_n   (dec_n[u*SLICE_N +: SLICE_N])
      );
    end
  endgenerate
endmodule

// File: rtl/casc_dec16_chk.sv
module casc_dec16_chk #(
  parameter int unsigned IN_W  = 4,
  parameter int unsigned OUT_W = 16
) (
  input logic             en_n,
  input logic [IN_W-1:0]  code,
  input logic [OUT_W-1:0] dec_n
);
  localparam int unsigned HALF = OUT_W / 2;

  always_comb begin
    if (en_n) begin
      AST_OFF_ALL_HIGH: assert (&dec_n);                        // R1
    end else begin
      AST_PICKED_LINE_LOW: assert (dec_n[code] == 1'b0);        // R2
    end
    AST_AT_MOST_ONE_LOW: assert ($onehot0(~dec_n));             // R5
    if (!code[IN_W-1]) begin
      AST_UPPER_IDLE: assert (&dec_n[OUT_W-1:HALF]);            // R3
    end else begin
      AST_LOWER_IDLE: assert (&dec_n[HALF-1:0]);                // R4
    end
  end
endmodule

bind casc_dec16 casc_dec16_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .en_n  (en_n),
  .code  (code),
  .dec_n (dec_n)
);

// File: tb/sim_casc_dec16.sv
module sim_casc_dec16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic        en_n;
  logic [3:0]  code;
  logic [15:0] dec_n;

  casc_dec16 u0 (.en_n(en_n), .code(code), .dec_n(dec_n));

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          done   = 0;

  // expected outputs with the enable asserted, indexed by code
  localparam logic [15:0] EXP_ON [16] = '{
    16'hFFFE, 16'hFFFD, 16'hFFFB, 16'hFFF7,
    16'hFFEF, 16'hFFDF, 16'hFFBF, 16'hFF7F,
    16'hFEFF, 16'hFDFF, 16'hFBFF, 16'hF7FF,
    16'hEFFF, 16'hDFFF, 16'hBFFF, 16'h7FFF
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s en_n=%b code=%0d actual=%h expected=%h", req, en_n, code, act, exp);
    end
  endtask

  task automatic apply(input logic e, input logic [3:0] c);
    @(negedge clk);
    en_n = e;
    code = c;
    #1;
  endtask

  initial begin
    en_n = 1'b1;
    code = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", dec_n, 16'hFFFF);
    rst = 1'b0;

    // table walk: every code with the enable on and off
    for (int i = 0; i < 16; i++) begin
      apply(1'b0, 4'(i));
      check("R2 enabled decode", dec_n, EXP_ON[i]);
      check("R5 at most one low", 16'($countones(~dec_n) <= 1), 16'd1);
      apply(1'b1, 4'(i));
      check("R1 disabled all high", dec_n, 16'hFFFF);
    end

    // R3: lower codes leave upper slice idle
    apply(1'b0, 4'd7);
    check("R3 upper idle", {8'h00, dec_n[15:8]}, 16'h00FF);
    apply(1'b0, 4'd0);
    check("R3 upper idle", {8'h00, dec_n[15:8]}, 16'h00FF);
    // R4: upper codes leave lower slice idle
    apply(1'b0, 4'd8);
    check("R4 lower idle", {8'h00, dec_n[7:0]}, 16'h00FF);
    apply(1'b0, 4'd15);
    check("R4 lower idle", {8'h00, dec_n[7:0]}, 16'h00FF);
    // chip select flip with same slice address
    apply(1'b0, 4'd3);
    check("R3 select low slice", dec_n, 16'hFFF7);
    apply(1'b0, 4'd11);
    check("R4 select high slice", dec_n, 16'hF7FF);
    // R6: address bit order
    apply(1'b0, 4'd1);
    check("R6 bit0 is LSB", dec_n, 16'hFFFD);
    apply(1'b0, 4'd4);
    check("R6 bit2 is slice MSB", dec_n, 16'hFFEF);
    apply(1'b0, 4'd6);
    check("R6 bits2,1", dec_n, 16'hFFBF);
    // enable toggled with code held
    apply(1'b1, 4'd9);
    check("R1 enable dropped", dec_n, 16'hFFFF);
    apply(1'b0, 4'd9);
    check("R2 enable restored", dec_n, 16'hFDFF);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule